// File: doc/BRIEF.md
# Serial DDS Tuning-Word Loader

This block drives the three-wire serial load port of an external direct digital synthesis chip. It has one data line, one write clock and one frequency-update strobe. Each request carries a 32-bit tuning word and an 8-bit control/phase byte through a valid/ready handshake. The block sends a 40-bit frame, least significant bit first, with the tuning word before the control byte. It then pulses the update strobe so that the chip applies the new word.

The chip powers up in a parallel load mode, so a fixed entry sequence must run once after reset before any frame is sent. In that sequence the data line is held low, the write clock is pulsed once, and then the update strobe is pulsed once. Every phase of every sequence lasts `PULSE_CYC` system clocks. The default is 200 cycles, which gives about 4 µs at 50 MHz. Only the divider value changes from one system clock rate to another.

Top module: `dds_serial_loader`

## Requirements
- R1: While reset is asserted and in the cycle after it, `ser_wclk`, `ser_latch`, `ser_data`, `req_ready`, `busy` and `done` are all low.
- R2: After reset the block runs the entry sequence before `req_ready` first rises. The sequence is: data held low, exactly one write-clock pulse, then exactly one strobe pulse. It raises `req_ready` exactly 4·`PULSE_CYC` clocks after reset is released.
- R3: Tuning-word bit k (k = 0..31) is on `ser_data` at the (k+1)-th rising edge of `ser_wclk` in a frame.
- R4: Control-byte bit j (j = 0..7) is on `ser_data` at rising edge 33+j, so each frame has exactly 40 write-clock edges.
- R5: Every write-clock high phase lasts exactly `PULSE_CYC` clocks. `ser_data` is set up at least one clock before each rising edge and holds steady while `ser_wclk` is high.
- R6: After the 40th bit there is a low gap of `PULSE_CYC` clocks, then exactly one `ser_latch` pulse of `PULSE_CYC` clocks. `ser_wclk` is never high while `ser_latch` is high. A frame takes 82·`PULSE_CYC` clocks from acceptance to `done`.
- R7: A request is accepted on a clock where `req_valid` and `req_ready` are both high. From the next cycle until the strobe falls, `busy` is high and `req_ready` is low. Request inputs that change during a frame have no effect on it.
- R8: `done` is a single-cycle pulse in the cycle after the strobe falls. In that same cycle `busy` is low and `req_ready` is high.
- R9: While the block is idle, `ser_wclk`, `ser_latch` and `ser_data` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_word | input | 32 | Tuning word to load |
| req_ctrl | input | 8 | Control/phase byte sent after the word |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when a frame has been committed |
| ser_data | output | 1 | Serial data to the chip |
| ser_wclk | output | 1 | Write clock; the chip samples on its rising edge |
| ser_latch | output | 1 | Frequency-update strobe |

## Verification
The assertions assume two things about the inputs. First, `rst_n` is held long enough for the divider counter to start from zero. Second, request fields matter only in the cycle of acceptance. Because the frame is captured into a shift register at acceptance, the assertions on data stability are made against the serial outputs only. The stimulus keeps to a single configuration with a short divider. While each frame is in flight, it deliberately drives `req_valid` high with a different word, and it drops that request before the block goes idle again. This way a premature acceptance would show up in the chip model, and no stray second frame can start.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;

   typedef enum logic [3:0] {
      ST_INIT_SETUP,
      ST_INIT_CLK,
      ST_INIT_GAP,
      ST_INIT_LATCH,
      ST_IDLE,
      ST_BIT_SETUP,
      ST_BIT_HIGH,
      ST_LATCH_GAP,
      ST_LATCH
   } ldr_state_e;

   localparam int unsigned LDR_WORD_W = 32;
   localparam int unsigned LDR_CTRL_W = 8;

endpackage

// File: rtl/dds_tick_gen.sv
module dds_tick_gen #(
   parameter int unsigned PULSE_CYC = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int unsigned CNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_CYC - 1);

   generate
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("PULSE_CYC must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   assign tick = (cnt_q == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (clr || tick) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> (cnt_q != '0)); // R5

endmodule

// File: rtl/dds_frame_shifter.sv
module dds_frame_shifter #(
   parameter int unsigned FRAME_W = 40
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_val,
   input  logic               shift,
   output logic               bit_out,
   output logic               last
);
   localparam int unsigned IDX_W = $clog2(FRAME_W);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_W - 1);

   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("FRAME_W must be at least 2");
      end
   endgenerate

   logic [FRAME_W-1:0] sreg_q;
   logic [IDX_W-1:0]   idx_q;

   assign bit_out = sreg_q[0];
   assign last    = (idx_q == IDX_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         idx_q  <= '0;
      end else if (load) begin
         sreg_q <= load_val;
         idx_q  <= '0;
      end else if (shift) begin
         sreg_q <= {1'b0, sreg_q[FRAME_W-1:1]};
         idx_q  <= last ? '0 : idx_q + 1'b1;
      end
   end

   AST_NO_LOAD_DURING_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift)); // R7

endmodule

// File: rtl/dds_serial_loader.sv
module dds_serial_loader
   import dds_ldr_pkg::*;
#(
   parameter int unsigned PULSE_CYC = 200,
   parameter int unsigned WORD_W    = LDR_WORD_W,
   parameter int unsigned CTRL_W    = LDR_CTRL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [WORD_W-1:0] req_word,
   input  logic [CTRL_W-1:0] req_ctrl,
   output logic              busy,
   output logic              done,
   output logic              ser_data,
   output logic              ser_wclk,
   output logic              ser_latch
);
   localparam int unsigned FRAME_W = WORD_W + CTRL_W;

   generate
      if (WORD_W < 1 || CTRL_W < 1) begin : g_bad_widths
         $error("WORD_W and CTRL_W must be non-zero");
      end
   endgenerate

   ldr_state_e st_q, st_nxt;
   logic       tick, accept, bit_out, last_bit, shift_en, done_q;

   assign accept   = (st_q == ST_IDLE) && req_valid;
   assign shift_en = (st_q == ST_BIT_HIGH) && tick;

   dds_tick_gen #(.PULSE_CYC(PULSE_CYC)) tick_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_q == ST_IDLE),
      .tick  (tick)
   );

   dds_frame_shifter #(.FRAME_W(FRAME_W)) shifter_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val ({req_ctrl, req_word}),
      .shift    (shift_en),
      .bit_out  (bit_out),
      .last     (last_bit)
   );

   always_comb begin
      st_nxt = st_q;
      unique case (st_q)
         ST_INIT_SETUP: if (tick) st_nxt = ST_INIT_CLK;
         ST_INIT_CLK:   if (tick) st_nxt = ST_INIT_GAP;
         ST_INIT_GAP:   if (tick) st_nxt = ST_INIT_LATCH;
         ST_INIT_LATCH: if (tick) st_nxt = ST_IDLE;
         ST_IDLE:       if (req_valid) st_nxt = ST_BIT_SETUP;
         ST_BIT_SETUP:  if (tick) st_nxt = ST_BIT_HIGH;
         ST_BIT_HIGH:   if (tick) st_nxt = last_bit ? ST_LATCH_GAP : ST_BIT_SETUP;
         ST_LATCH_GAP:  if (tick) st_nxt = ST_LATCH;
         ST_LATCH:      if (tick) st_nxt = ST_IDLE;
         default:       st_nxt = ST_INIT_SETUP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_INIT_SETUP;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_nxt;
         done_q <= (st_q == ST_LATCH) && tick;
      end
   end

   assign req_ready = (st_q == ST_IDLE);
   assign busy      = (st_q == ST_BIT_SETUP) || (st_q == ST_BIT_HIGH) ||
                      (st_q == ST_LATCH_GAP) || (st_q == ST_LATCH);
   assign done      = done_q;
   assign ser_wclk  = (st_q == ST_INIT_CLK) || (st_q == ST_BIT_HIGH);
   assign ser_latch = (st_q == ST_INIT_LATCH) || (st_q == ST_LATCH);
   assign ser_data  = ((st_q == ST_BIT_SETUP) || (st_q == ST_BIT_HIGH)) && bit_out;

   AST_NO_WCLK_IN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !(ser_wclk && ser_latch)); // R6
   AST_READY_EXCL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready && busy)); // R7
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (busy && !req_ready)); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_DONE_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($fell(ser_latch) && req_ready)); // R8
   AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_wclk) |-> $stable(ser_data)); // R5
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_wclk && $past(ser_wclk)) |-> $stable(ser_data)); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!ser_wclk && !ser_latch && !ser_data)); // R9

endmodule

// File: tb/dds_serial_loader_tb_top.sv
module dds_serial_loader_tb_top;
   localparam int P = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_word = '0;
   logic [7:0]  req_ctrl = '0;
   logic        req_ready, busy, done, ser_data, ser_wclk, ser_latch;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   dds_serial_loader #(.PULSE_CYC(P)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_word(req_word), .req_ctrl(req_ctrl), .busy(busy), .done(done),
      .ser_data(ser_data), .ser_wclk(ser_wclk), .ser_latch(ser_latch));

   // Receiving chip model: 40-bit register shifted in from the top
   logic [39:0] cap = '0;
   logic [39:0] lat_val = '0;
   int edges = 0, latches = 0, lat_edges = 0, overlap = 0;
   always @(posedge ser_wclk) begin
      cap = {ser_data, cap[39:1]};
      edges++;
      if (ser_latch) overlap++;
   end
   always @(posedge ser_latch) begin
      latches++;
      lat_val = cap;
      lat_edges = edges;
   end

   // Pulse width monitor, sampled away from the active edge
   int wh = 0, lh = 0, wbad = 0, lbad = 0;
   always @(negedge clk) begin
      if (ser_wclk) wh++;
      else if (wh != 0) begin if (wh != P) wbad++; wh = 0; end
      if (ser_latch) lh++;
      else if (lh != 0) begin if (lh != P) lbad++; lh = 0; end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic clear_model();
      edges = 0; latches = 0; lat_edges = 0; overlap = 0; wbad = 0; lbad = 0;
   endtask

   task automatic send(input logic [31:0] w, input logic [7:0] c);
      int n;
      clear_model();
      @(negedge clk);
      req_valid = 1'b1; req_word = w; req_ctrl = c;
      @(negedge clk);
      chk(busy && !req_ready, "R7 busy after accept", {busy, req_ready}, 2'b10);
      // conflicting request while busy must be ignored
      req_word = ~w; req_ctrl = ~c;
      n = 0;
      while (!done && n < 100000) begin
         @(negedge clk);
         n++;
         if (n == 20) req_valid = 1'b0;
      end
      chk(n == 82 * P, "R6 frame length", n, 82 * P);
      chk(!busy && req_ready, "R8 ready with done", {busy, req_ready}, 2'b01);
      chk(cap[31:0] == w, "R3 word bits", cap[31:0], w);
      chk(cap[39:32] == c, "R4 ctrl bits", cap[39:32], c);
      chk(edges == 40, "R4 edge count", edges, 40);
      chk(latches == 1 && lat_edges == 40 && lat_val == {c, w}, "R6 latch", lat_val, {c, w});
      chk(overlap == 0 && lbad == 0, "R6 no clock in latch / width", overlap + lbad, 0);
      chk(wbad == 0, "R5 wclk high width", wbad, 0);
      @(negedge clk);
      chk(!done, "R8 done single cycle", done, 0);
      chk(!ser_wclk && !ser_latch && !ser_data, "R9 idle lines low",
          {ser_wclk, ser_latch, ser_data}, 0);
      chk(edges == 40, "R7 no extra frame", edges, 40);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      chk({ser_wclk, ser_latch, ser_data, req_ready, busy, done} == 0, "R1 reset state",
          {ser_wclk, ser_latch, ser_data, req_ready, busy, done}, 0);
      rst_n = 1'b1;
      n = 0;
      while (!req_ready && n < 10000) begin @(negedge clk); n++; end
      chk(n == 4 * P, "R2 init duration", n, 4 * P);
      chk(edges == 1 && cap[39] == 1'b0, "R2 init clock with data low", {edges, cap[39]}, 2);
      chk(latches == 1 && lat_edges == 1, "R2 latch after clock", {latches, lat_edges}, 32'h101);
      chk(wbad == 0 && lbad == 0, "R2 init pulse widths", wbad + lbad, 0);
      send(32'h0000_0000, 8'h00);
      send(32'hFFFF_FFFF, 8'hFF);
      send(32'h0000_0001, 8'h00);
      send(32'h8000_0000, 8'h01);
      send(32'hA5A5_A5A5, 8'h5A);
      send(32'h1234_5678, 8'h80);
      for (int i = 0; i < 32; i += 7) send(32'h1 << i, 8'(i));
      report();
   end
endmodule